// File: doc/BRIEF.md
# Key-Protected Watchdog Timer

This block is a watchdog timer with an 8-bit up-counter and an 8-bit control register, reached over a single-cycle register bus. To keep a runaway program from reconfiguring or feeding the watchdog by accident, every write must carry a fixed key byte in the top byte of the bus word. The key differs per register. A write with the wrong key changes nothing. It only raises a one-cycle rejection strobe.

A 3-bit rate field in the control register sets the counter tick period to 2^(5+rate) input clock cycles, from 1/32 up to 1/4096 of the input clock. Each step doubles the time to overflow. When the counter wraps from 0xFF to 0x00, a sticky overflow flag is set and a one-cycle overflow pulse is driven. A system reset generator or interrupt logic outside the block consumes that pulse. Software keeps the watchdog from firing by reloading the counter with the counter key. That reload also restarts the prescaler phase.

Top module: `kwdt_top`

## Requirements
- R1: After reset the counter reads 0x00, the control register reads 0x00 (disabled, rate 0, flag clear), and `ovfPulse` and `keyErr` are low.
- R2: A write to the counter (`wrSel`=0) whose bits [BUS_W-1:BUS_W-8] equal 0x5A loads `wrData[7:0]` into the counter, and the new value can be read the cycle after the write edge.
- R3: A write to the control register (`wrSel`=1) whose top byte equals 0xA5 sets bit 7 (run enable) and bits 2:0 (rate) from the write data. Writing 0 to bit 3 (overflow flag) clears the flag. Writing 1 to bit 3 leaves the flag unchanged. Bits 6:4 always read 0.
- R4: A write whose top byte does not match the key of the addressed register leaves both registers unchanged, and `keyErr` is high for exactly the one cycle after the write edge.
- R5: While run enable is set, the counter advances by one every 2^(5+rate) cycles. While it is clear, the counter holds and the prescaler is held at zero, so the first increment after enabling comes a full period later.
- R6: An accepted counter write restarts the prescaler. The first increment comes exactly 2^(5+rate) cycles after the write edge.
- R7: When the counter wraps from 0xFF to 0x00, the flag (bit 3) becomes set and `ovfPulse` is high for one cycle, in the same cycle that the counter first reads 0x00.
- R8: The flag stays set until an accepted control write with bit 3 = 0. If a wrap and such a clearing write fall on the same edge, the flag ends up set.
- R9: `rdData` shows the counter when `rdSel`=0 and the control register when `rdSel`=1, combinationally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock; also the prescaler source |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Single-cycle write strobe |
| wrSel | input | 1 | Write target: 0 counter, 1 control |
| wrData | input | BUS_W | Write word: key in top byte, data in bits 7:0 |
| rdSel | input | 1 | Read target: 0 counter, 1 control |
| rdData | output | 8 | Selected register value |
| ovfPulse | output | 1 | One-cycle pulse on counter wrap |
| keyErr | output | 1 | One-cycle pulse after a rejected write |

## Verification
The hardest situation to reach is an overflow at the slow rates and the exact tick boundary behind it. Counting up from zero at rate 7 would take over a million cycles. Instead, the bench preloads the counter to 0xFD with a keyed write, which also fixes the prescaler phase, and then expects each increment at an exact multiple of the computed period for all eight rates. The case of a wrap colliding with a flag-clearing write is set up by counting cycles from the reload so that the clearing write lands on the wrap edge.

// File: rtl/kwdt_pkg.sv
package kwdt_pkg;
  localparam int REG_W = 8;
  localparam int SEL_W = 3;
  localparam logic [7:0] CNT_KEY = 8'h5A;
  localparam logic [7:0] CSR_KEY = 8'hA5;

  // Strobes from control to datapath for one accepted write
  typedef struct packed {
    logic             loadCnt;
    logic             loadCsr;
    logic [REG_W-1:0] cntVal;
    logic             csrEn;
    logic             csrFlagKeep;
    logic [SEL_W-1:0] csrSel;
  } wrStrobe_t;
endpackage

// File: rtl/kwdt_ctrl.sv
module kwdt_ctrl
  import kwdt_pkg::*;
#(
  parameter int BUS_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic             wrSel,
  input  logic [BUS_W-1:0] wrData,
  output wrStrobe_t        strb,
  output logic             keyErr
);
  localparam int KEY_LSB = BUS_W - 8;

  logic [7:0] keyByte;
  logic       keyOk;
  logic       badWrite;

  assign keyByte  = wrData[BUS_W-1:KEY_LSB];
  assign keyOk    = wrSel ? (keyByte == CSR_KEY) : (keyByte == CNT_KEY);
  assign badWrite = wrEn && !keyOk;

  always_comb begin
    strb.loadCnt     = wrEn && keyOk && !wrSel;
    strb.loadCsr     = wrEn && keyOk && wrSel;
    strb.cntVal      = wrData[REG_W-1:0];
    strb.csrEn       = wrData[7];
    strb.csrFlagKeep = wrData[3];
    strb.csrSel      = wrData[SEL_W-1:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) keyErr <= 1'b0;
    else       keyErr <= badWrite;
  end

  // R4
  keyerr_src_chk: assert property (@(posedge clk) disable iff (!rstN)
    keyErr |-> $past(wrEn));

  // R4
  no_load_on_err_chk: assert property (@(posedge clk) disable iff (!rstN)
    badWrite |-> !(strb.loadCnt || strb.loadCsr));
endmodule

// File: rtl/kwdt_datapath.sv
module kwdt_datapath
  import kwdt_pkg::*;
#(
  parameter int BASE_LOG2 = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  wrStrobe_t        strb,
  input  logic             rdSel,
  output logic [REG_W-1:0] rdData,
  output logic             ovfPulse
);
  localparam int NSEL  = 1 << SEL_W;
  localparam int PRE_W = BASE_LOG2 + NSEL - 1;

  logic [PRE_W-1:0] limTab [NSEL];
  logic [PRE_W-1:0] prescQ;
  logic [REG_W-1:0] cntQ;
  logic             enQ;
  logic             flagQ;
  logic [SEL_W-1:0] selQ;
  logic             tick;
  logic             wrap;

  // One terminal phase value per rate setting
  for (genvar g = 0; g < NSEL; g++) begin : g_lim
    assign limTab[g] = PRE_W'((64'd1 << (BASE_LOG2 + g)) - 64'd1);
  end

  // >= so a rate lowered mid-period ticks at once instead of wrapping
  assign tick = enQ && (prescQ >= limTab[selQ]);
  assign wrap = tick && !strb.loadCnt && (cntQ == {REG_W{1'b1}});

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prescQ <= '0;
      cntQ   <= '0;
    end else if (strb.loadCnt) begin
      prescQ <= '0;
      cntQ   <= strb.cntVal;
    end else if (!enQ || tick) begin
      prescQ <= '0;
      if (tick) cntQ <= cntQ + 1'b1;
    end else begin
      prescQ <= prescQ + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enQ      <= 1'b0;
      selQ     <= '0;
      flagQ    <= 1'b0;
      ovfPulse <= 1'b0;
    end else begin
      if (strb.loadCsr) begin
        enQ  <= strb.csrEn;
        selQ <= strb.csrSel;
      end
      flagQ    <= wrap || (flagQ && (!strb.loadCsr || strb.csrFlagKeep));
      ovfPulse <= wrap;
    end
  end

  assign rdData = rdSel ? {enQ, 3'b000, flagQ, selQ} : cntQ;

  // R7
  ovf_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    ovfPulse |-> (cntQ == '0 && flagQ));

  // R5
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.loadCnt && !enQ) |=> $stable(cntQ));

  // R6
  presc_restart_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadCnt |=> (prescQ == '0));

  // R8
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (flagQ && !strb.loadCsr) |=> flagQ);

  // R8
  wrap_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrap |=> flagQ);
endmodule

// File: rtl/kwdt_top.sv
module kwdt_top
  import kwdt_pkg::*;
#(
  parameter int BUS_W     = 16,
  parameter int BASE_LOG2 = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic             wrSel,
  input  logic [BUS_W-1:0] wrData,
  input  logic             rdSel,
  output logic [7:0]       rdData,
  output logic             ovfPulse,
  output logic             keyErr
);
  wrStrobe_t strb;

  kwdt_ctrl #(.BUS_W(BUS_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrSel(wrSel),
    .wrData(wrData), .strb(strb), .keyErr(keyErr)
  );

  kwdt_datapath #(.BASE_LOG2(BASE_LOG2)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .rdSel(rdSel),
    .rdData(rdData), .ovfPulse(ovfPulse)
  );
endmodule

// File: tb/tb_kwdt_top.sv
`timescale 1ns/1ps
module tb_kwdt_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic        wrSel = 1'b0;
  logic [15:0] wrData = '0;
  logic        rdSel = 1'b0;
  logic [7:0]  rdData;
  logic        ovfPulse;
  logic        keyErr;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  kwdt_top dut (.clk(clk), .rstN(rstN), .wrEn(wrEn), .wrSel(wrSel),
    .wrData(wrData), .rdSel(rdSel), .rdData(rdData),
    .ovfPulse(ovfPulse), .keyErr(keyErr));

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Write lands on the edge after the first negedge; returns at the negedge after it
  task automatic wr(bit sel, logic [7:0] key, logic [7:0] data);
    @(negedge clk);
    wrEn = 1'b1; wrSel = sel; wrData = {key, data};
    @(negedge clk);
    wrEn = 1'b0; wrData = '0;
  endtask

  task automatic rd(bit sel, output logic [7:0] v);
    rdSel = sel; #0.5; v = rdData;
  endtask

  task automatic waitn(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    logic [7:0] v;
    int per;
    waitn(3);
    rstN = 1'b1;
    waitn(1);
    // R1 reset state
    rd(0, v); chk("R1 counter", v, 8'h00);
    rd(1, v); chk("R1 control", v, 8'h00);
    chk("R1 ovfPulse", ovfPulse, 0);
    chk("R1 keyErr", keyErr, 0);

    // R4 wrong keys
    wr(0, 8'hA5, 8'h33);
    chk("R4 keyErr counter", keyErr, 1);
    rd(0, v); chk("R4 counter kept", v, 8'h00);
    waitn(1); chk("R4 keyErr one cycle", keyErr, 0);
    wr(1, 8'h5A, 8'h87);
    chk("R4 keyErr control", keyErr, 1);
    rd(1, v); chk("R4 control kept", v, 8'h00);
    wr(1, 8'h00, 8'h87);
    rd(1, v); chk("R4 control kept zero key", v, 8'h00);

    // R2 keyed counter load, R5 hold while disabled
    wr(0, 8'h5A, 8'h42);
    chk("R2 no keyErr", keyErr, 0);
    rd(0, v); chk("R2 counter loaded", v, 8'h42);
    waitn(100);
    rd(0, v); chk("R5 disabled hold", v, 8'h42);

    // R3 control fields
    wr(1, 8'hA5, 8'hF5);
    rd(1, v); chk("R3 control fields", v, 8'h85);
    wr(1, 8'hA5, 8'h0D);
    rd(1, v); chk("R3 flag not settable", v, 8'h05);

    // R5 R6 R7 R8 sweep over all rates
    for (int s = 0; s < 8; s++) begin
      per = 32 << s;
      wr(1, 8'hA5, 8'h80 | s[7:0]);
      wr(0, 8'h5A, 8'hFD);
      rd(0, v); chk("R6 reload", v, 8'hFD);
      waitn(per - 1); rd(0, v); chk("R6 before first tick", v, 8'hFD);
      waitn(1); rd(0, v); chk("R6 first tick", v, 8'hFE);
      waitn(per - 1); rd(0, v); chk("R5 before second tick", v, 8'hFE);
      waitn(1); rd(0, v); chk("R5 second tick", v, 8'hFF);
      waitn(per - 1);
      chk("R7 no early pulse", ovfPulse, 0);
      rd(1, v); chk("R7 no early flag", v, 8'h80 | s);
      waitn(1);
      chk("R7 pulse", ovfPulse, 1);
      rd(0, v); chk("R7 wrapped", v, 8'h00);
      rd(1, v); chk("R7 flag", v, 8'h88 | s);
      waitn(1); chk("R7 pulse one cycle", ovfPulse, 0);
      waitn(5); rd(1, v); chk("R8 flag sticky", v, 8'h88 | s);
      wr(1, 8'h5A, 8'h80 | s[7:0]);
      rd(1, v); chk("R8 bad key no clear", v, 8'h88 | s);
      wr(1, 8'hA5, 8'h88 | s[7:0]);
      rd(1, v); chk("R8 write one keeps flag", v, 8'h88 | s);
      wr(1, 8'hA5, 8'h80 | s[7:0]);
      rd(1, v); chk("R8 cleared", v, 8'h80 | s);
      wr(1, 8'hA5, 8'h00);
    end

    // R5 prescaler cleared while disabled
    wr(1, 8'hA5, 8'h80);
    wr(0, 8'h5A, 8'h10);
    waitn(20);
    wr(1, 8'hA5, 8'h00);
    waitn(10);
    rd(0, v); chk("R5 paused", v, 8'h10);
    wr(1, 8'hA5, 8'h80);
    waitn(31); rd(0, v); chk("R5 full period after enable", v, 8'h10);
    waitn(1); rd(0, v); chk("R5 tick after enable", v, 8'h11);

    // R7 full period from zero at rate 0
    wr(0, 8'h5A, 8'h00);
    waitn(256 * 32 - 1);
    chk("R7 full run no pulse", ovfPulse, 0);
    rd(0, v); chk("R7 full run at FF", v, 8'hFF);
    waitn(1);
    chk("R7 full run pulse", ovfPulse, 1);

    // R8 wrap and clear on the same edge: flag stays set
    wr(0, 8'h5A, 8'hFF);
    waitn(30);
    wr(1, 8'hA5, 8'h80);
    chk("R8 collide pulse", ovfPulse, 1);
    rd(1, v); chk("R8 wrap beats clear", v, 8'h88);
    wr(1, 8'hA5, 8'h80);
    rd(1, v); chk("R8 later clear", v, 8'h80);

    // R9 read select
    wr(0, 8'h5A, 8'h3C);
    wr(1, 8'hA5, 8'h06);
    rd(0, v); chk("R9 read counter", v, 8'h3C);
    rd(1, v); chk("R9 read control", v, 8'h06);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule